// File: doc/BRIEF.md
# Mode-Gated General-Purpose I/O Port

This block is an eight-bit general-purpose I/O port that sits on a simple register bus. It holds an output latch, a per-pin direction register, a pull-up enable bit and a reduced-drive bit. It drives a modelled pad interface: an output value, an output enable, a pull-up enable and a reduced-drive flag for each pin. Pin levels come back through a two-stage synchronizer.

The chip operating mode arrives on a two-bit input. In single-chip mode the pins belong to the port and every register is visible. In the expanded modes the pins belong to an external bus controller. The output enables are then held off, and the data and direction registers leave the map. In peripheral mode the pull-up and drive registers also leave the map. The drive register accepts one write after reset, and every later write is discarded.

Top module: `gpio_port`

## Requirements
- R1: After reset the output latch, the direction register, the pull-up bit and the drive bit are all zero, and every output enable is low.
- R2: In single-chip mode (mode 2'b00), a read of address 0 returns the output latch on pins whose direction bit is 1 and the synchronized pin level on pins whose direction bit is 0. A write to address 0 loads the latch, and a write to address 1 loads the direction register, which reads back at address 1.
- R3: In single-chip mode padOe equals the direction register (1 = output) and padOut equals the output latch.
- R4: In expanded (2'b01, 2'b11) and peripheral (2'b10) modes, reads of addresses 0 and 1 return zero and writes to them change nothing.
- R5: In any mode other than single-chip, padOe is all zero.
- R6: When the pull-up bit (address 2, bit 0) is 1, padPullUp is 1 on every pin whose output enable is low; when the bit is 0, padPullUp is all zero.
- R7: When the drive bit (address 3, bit 0) is 1, padLowDrive is 1 on every pin whose output enable is high; otherwise it is all zero.
- R8: Only the first mapped write to address 3 after reset changes the drive bit. Later writes are ignored, and a write made while address 3 is unmapped does not use up the one write.
- R9: Addresses 2 and 3 read as zero and ignore writes in peripheral mode, and are fully mapped in single-chip and expanded modes.
- R10: Addresses 4 and above read as zero and writes to them change no state.
- R11: A change on padIn reaches the address-0 read value two clock edges later, not one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Chip operating mode: 00 single-chip, 01/11 expanded, 10 peripheral |
| busSel | input | 1 | Bus access strobe |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 4 | Register address |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, combinational, zero when not reading a mapped register |
| padIn | input | 8 | Pin levels from the pads |
| padOut | output | 8 | Output value to the pads |
| padOe | output | 8 | Output enable per pin |
| padPullUp | output | 8 | Pull-up enable per pin |
| padLowDrive | output | 8 | Reduced-drive flag per pin |

## Verification
The bench targets writes to the drive register made while it is unmapped and before the first mapped write. A design that counted those writes would lock with the wrong value. It also checks that a read of address 0 one edge after a pin change still shows the old level; a single-stage or missing synchronizer shows the new level too early. Accesses to the data and direction registers outside single-chip mode, and pins split between input and output, expose designs that leave a register mapped, leak enables to an external bus master, or compute pull-up and drive flags from the wrong pins. Random mode switches mixed with random accesses are then compared against a bench model of the register state.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [1:0] {
    MODE_SINGLE  = 2'b00,
    MODE_EXP_WID = 2'b01,
    MODE_PERIPH  = 2'b10,
    MODE_EXP_NAR = 2'b11
  } chipMode_e;

  localparam int unsigned ADDR_DATA  = 0;
  localparam int unsigned ADDR_DIR   = 1;
  localparam int unsigned ADDR_PULL  = 2;
  localparam int unsigned ADDR_DRIVE = 3;

  typedef enum logic [2:0] {
    RD_NONE, RD_DATA, RD_DIR, RD_PULL, RD_DRIVE
  } rdSel_e;

  typedef struct packed {
    logic   wrData;
    logic   wrDir;
    logic   wrPull;
    logic   wrDrive;
    rdSel_e rdSel;
  } strobe_t;

endpackage

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [1:0]        mode,
  input  logic              drvLocked,
  output strobe_t           strb,
  output logic              gpioOwns
);

  logic singleChip, periph, mapCore, mapCtl;
  logic hitData, hitDir, hitPull, hitDrive, doWr, doRd;

  assign singleChip = (mode == MODE_SINGLE);
  assign periph     = (mode == MODE_PERIPH);
  assign mapCore    = singleChip;
  assign mapCtl     = !periph;
  assign gpioOwns   = singleChip;

  assign hitData  = (busAddr == ADDR_W'(ADDR_DATA));
  assign hitDir   = (busAddr == ADDR_W'(ADDR_DIR));
  assign hitPull  = (busAddr == ADDR_W'(ADDR_PULL));
  assign hitDrive = (busAddr == ADDR_W'(ADDR_DRIVE));

  assign doWr = busSel && busWr;
  assign doRd = busSel && !busWr;

  always_comb begin
    strb.wrData  = doWr && hitData && mapCore;
    strb.wrDir   = doWr && hitDir && mapCore;
    strb.wrPull  = doWr && hitPull && mapCtl;
    strb.wrDrive = doWr && hitDrive && mapCtl && !drvLocked;
    strb.rdSel   = RD_NONE;
    if (doRd) begin
      if (hitData && mapCore)       strb.rdSel = RD_DATA;
      else if (hitDir && mapCore)   strb.rdSel = RD_DIR;
      else if (hitPull && mapCtl)   strb.rdSel = RD_PULL;
      else if (hitDrive && mapCtl)  strb.rdSel = RD_DRIVE;
    end
  end

endmodule

// File: rtl/gpio_port_dp.sv
module gpio_port_dp
  import gpio_port_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [WIDTH-1:0] busWdata,
  input  logic [WIDTH-1:0] padIn,
  input  logic             gpioOwns,
  output logic [WIDTH-1:0] busRdata,
  output logic [WIDTH-1:0] padOut,
  output logic [WIDTH-1:0] padOe,
  output logic             pullBit,
  output logic             drvBit,
  output logic             drvLocked
);

  logic [WIDTH-1:0] dataQ, dirQ;
  logic [WIDTH-1:0] syncQ [SYNC_STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ     <= '0;
      dirQ      <= '0;
      pullBit   <= 1'b0;
      drvBit    <= 1'b0;
      drvLocked <= 1'b0;
    end else begin
      if (strb.wrData) dataQ   <= busWdata;
      if (strb.wrDir)  dirQ    <= busWdata;
      if (strb.wrPull) pullBit <= busWdata[0];
      if (strb.wrDrive) begin
        drvBit    <= busWdata[0];
        drvLocked <= 1'b1;
      end
    end
  end

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[s] <= '0;
        else if (s == 0) syncQ[s] <= padIn;
        else syncQ[s] <= syncQ[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign padOut = dataQ;
  assign padOe  = gpioOwns ? dirQ : '0;

  always_comb begin
    unique case (strb.rdSel)
      RD_DATA:  busRdata = (dataQ & dirQ) | (syncQ[SYNC_STAGES-1] & ~dirQ);
      RD_DIR:   busRdata = dirQ;
      RD_PULL:  busRdata = WIDTH'(pullBit);
      RD_DRIVE: busRdata = WIDTH'(drvBit);
      default:  busRdata = '0;
    endcase
  end

endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        mode,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [WIDTH-1:0]  busWdata,
  output logic [WIDTH-1:0]  busRdata,
  input  logic [WIDTH-1:0]  padIn,
  output logic [WIDTH-1:0]  padOut,
  output logic [WIDTH-1:0]  padOe,
  output logic [WIDTH-1:0]  padPullUp,
  output logic [WIDTH-1:0]  padLowDrive
);

  strobe_t strb;
  logic gpioOwns, drvLocked, pullBit, drvBit;

  gpio_port_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busSel(busSel), .busWr(busWr), .busAddr(busAddr), .mode(mode),
    .drvLocked(drvLocked), .strb(strb), .gpioOwns(gpioOwns)
  );

  gpio_port_dp #(.WIDTH(WIDTH), .SYNC_STAGES(2)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busWdata(busWdata), .padIn(padIn),
    .gpioOwns(gpioOwns), .busRdata(busRdata), .padOut(padOut), .padOe(padOe),
    .pullBit(pullBit), .drvBit(drvBit), .drvLocked(drvLocked)
  );

  assign padPullUp   = pullBit ? ~padOe : '0;
  assign padLowDrive = drvBit ? padOe : '0;

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int WIDTH  = 8,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        mode,
  input logic              busSel,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic [WIDTH-1:0]  busRdata,
  input logic [WIDTH-1:0]  padOe,
  input logic [WIDTH-1:0]  padPullUp,
  input logic [WIDTH-1:0]  padLowDrive,
  input logic              drvLocked,
  input logic              drvBit
);

  p_oe_off_r5: assert property (@(posedge clk) disable iff (!rstN)
    (mode != 2'b00) |-> (padOe == '0));

  p_pull_inputs_r6: assert property (@(posedge clk) disable iff (!rstN)
    (padPullUp & padOe) == '0);

  p_lowdrive_outputs_r7: assert property (@(posedge clk) disable iff (!rstN)
    (padLowDrive & ~padOe) == '0);

  p_drive_once_r8: assert property (@(posedge clk) disable iff (!rstN)
    drvLocked |=> (drvLocked && $stable(drvBit)));

  p_core_unmapped_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWr && mode != 2'b00 && busAddr < ADDR_W'(2)) |-> (busRdata == '0));

  p_ctl_unmapped_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWr && mode == 2'b10 && (busAddr == ADDR_W'(2) || busAddr == ADDR_W'(3)))
      |-> (busRdata == '0));

  p_high_addr_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWr && busAddr >= ADDR_W'(4)) |-> (busRdata == '0));

endmodule

bind gpio_port gpio_port_chk #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .mode(mode), .busSel(busSel), .busWr(busWr),
  .busAddr(busAddr), .busRdata(busRdata), .padOe(padOe), .padPullUp(padPullUp),
  .padLowDrive(padLowDrive), .drvLocked(drvLocked), .drvBit(drvBit)
);

// File: tb/gpio_port_tb.sv
`timescale 1ns/1ps
module gpio_port_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       busSel = 1'b0, busWr = 1'b0;
  logic [3:0] busAddr = '0;
  logic [7:0] busWdata = '0, padIn = '0;
  logic [7:0] busRdata, padOut, padOe, padPullUp, padLowDrive;

  int testCnt = 0, failCnt = 0;
  bit done = 1'b0;

  logic [7:0] mData = '0, mDir = '0;
  logic mPull = 1'b0, mDrv = 1'b0, mDrvDone = 1'b0;

  always #2 clk = ~clk;

  gpio_port u_dut (
    .clk(clk), .rstN(rstN), .mode(mode), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .padPullUp(padPullUp), .padLowDrive(padLowDrive)
  );

  function automatic logic [7:0] expRead(input logic [3:0] a, input logic [1:0] m,
                                         input logic [7:0] pins);
    if (a == 4'd0 && m == 2'b00) return (mData & mDir) | (pins & ~mDir);
    if (a == 4'd1 && m == 2'b00) return mDir;
    if (a == 4'd2 && m != 2'b10) return {7'd0, mPull};
    if (a == 4'd3 && m != 2'b10) return {7'd0, mDrv};
    return 8'd0;
  endfunction

  function automatic logic [7:0] expOe(input logic [1:0] m);
    return (m == 2'b00) ? mDir : 8'd0;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic checkPins(input string tag);
    logic [7:0] oe;
    oe = expOe(mode);
    check({tag, " R3/R5 oe"}, padOe, oe);
    check({tag, " R3 out"}, padOut, mData);
    check({tag, " R6 pull"}, padPullUp, mPull ? ~oe : 8'd0);
    check({tag, " R7 drive"}, padLowDrive, mDrv ? oe : 8'd0);
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk);
    if (a == 4'd0 && mode == 2'b00) mData = d;
    if (a == 4'd1 && mode == 2'b00) mDir = d;
    if (a == 4'd2 && mode != 2'b10) mPull = d[0];
    if (a == 4'd3 && mode != 2'b10 && !mDrvDone) begin mDrv = d[0]; mDrvDone = 1'b1; end
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic busRead(input string req, input logic [3:0] a);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1;
    check(req, busRdata, expRead(a, mode, padIn));
    busSel = 1'b0;
  endtask

  task automatic setPins(input logic [7:0] v);
    @(negedge clk);
    padIn = v;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R1 reset state
    checkPins("R1 reset");
    for (int a = 0; a < 4; a++) busRead("R1 reset read", 4'(a));

    // R2/R3 single-chip data and direction
    busWrite(4'd0, 8'hA5);
    busWrite(4'd1, 8'h0F);
    setPins(8'h3C);
    busRead("R2 data read mixed", 4'd0);
    check("R2 literal", expRead(4'd0, 2'b00, 8'h3C), 8'h35);
    busRead("R2 dir read", 4'd1);
    checkPins("R3 single");

    // R11 two-stage input sync
    @(negedge clk); padIn = 8'hC3;
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = 4'd0; #1;
    check("R11 one edge old", busRdata, 8'h35);
    busSel = 1'b0;
    @(negedge clk);
    busSel = 1'b1; #1;
    check("R11 two edges new", busRdata, 8'hC5);
    busSel = 1'b0;

    // R6 pull-ups on inputs
    busWrite(4'd2, 8'h01);
    checkPins("R6 pull on");

    // R4/R5 expanded: core registers unmapped
    @(negedge clk); mode = 2'b01;
    busWrite(4'd0, 8'hFF);
    busWrite(4'd1, 8'hFF);
    busRead("R4 exp data read", 4'd0);
    busRead("R4 exp dir read", 4'd1);
    checkPins("R5 expanded");

    // R8/R9 peripheral: control registers unmapped, drive write not consumed
    @(negedge clk); mode = 2'b10;
    busWrite(4'd3, 8'h00);
    busWrite(4'd2, 8'h00);
    busRead("R9 periph pull read", 4'd2);
    busRead("R9 periph drive read", 4'd3);
    checkPins("R5 periph");
    @(negedge clk); mode = 2'b11;
    busRead("R9 exp pull mapped", 4'd2);
    busWrite(4'd3, 8'h01);
    busWrite(4'd3, 8'h00);
    busRead("R8 drive locked at 1", 4'd3);
    check("R8 model", {7'd0, mDrv}, 8'h01);
    @(negedge clk); mode = 2'b00;
    busWrite(4'd0, 8'hFF);
    busRead("R4 after return core intact", 4'd1);
    checkPins("R7 single drive");

    // R10 high addresses
    busWrite(4'd9, 8'hFF);
    busRead("R10 high read", 4'd9);
    busRead("R10 state kept", 4'd1);
    checkPins("R10 pins");

    // Random phase
    for (int i = 0; i < 400; i++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op == 0) begin @(negedge clk); mode = 2'($urandom_range(0, 3)); end
      else if (op == 1) setPins(8'($urandom));
      else if (op < 6) busWrite(4'($urandom_range(0, 7)), 8'($urandom));
      else busRead("R2/R4/R9/R10 random read", 4'($urandom_range(0, 7)));
      @(negedge clk);
      checkPins("random");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule